// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

This block is a bank of 32 general-purpose lines behind a small 32-bit register bus. The bus has select, write, address, write-data, read-data and ready signals. Every access finishes in the cycle it is presented: `pready` stays high, reads are decoded combinationally from the address, and writes take effect at the next rising clock edge. Software never rewrites direction or output data in place. It changes them only through write-one-to-set and write-one-to-clear aliases, so two agents that touch different lines cannot undo each other's work.

The eight lowest lines also feed an interrupt unit. All of its settings live in one packed control word, which is changed through its own set and clear aliases. Each line has a rising-enable bit, a falling-enable bit, a debounce bit and a level-mode bit. Edge hits are held in sticky status bits that software clears by writing ones. In level mode, status follows the live pin condition. A single output, `irq_o`, is raised whenever any status bit is set. Every input passes through a two-flop synchronizer before anything looks at it.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every line is an input, the output latch and the interrupt-control word are zero, status reads zero and `irq_o` is low.
- R2: `pready` is always high. Writing ones to 0x04 makes those lines outputs and writing ones to 0x08 makes them inputs. Zero bits leave a line unchanged. Address 0x00 reads the direction, where 1 means output, and `poe_o` mirrors it from the cycle after the write. Addresses with no register read zero.
- R3: Writing ones to 0x10 sets output-latch bits and writing ones to 0x14 clears them. The latch reads back at 0x10 and drives `pout_o`.
- R4: Address 0x0C returns the pin state after the two-flop synchronizer.
- R5: Writing ones to 0x18 sets bits of the interrupt-control word and writing ones to 0x1C clears them. The word reads back at 0x18. Its fields, for lines 0–7, are: bits 7:0 rise, bits 15:8 fall, bits 23:16 debounce, bits 31:24 level mode.
- R6: When a line's level-mode bit is clear, its rise bit latches its status bit on a rising edge and its fall bit latches it on a falling edge. The status bit sits at the line's position in 0x24 and stays set once latched.
- R7: Writing a one to a bit of 0x20 clears that line's latched edge status. Zero bits in the write leave other lines' status unchanged.
- R8: When a line's level-mode bit is set, its status bit is high while the rise bit is set and the pin is high, or while the fall bit is set and the pin is low. A write to 0x20 cannot clear it while that condition holds.
- R9: A line with both rise and fall bits clear shows zero status, whatever its level-mode bit says.
- R10: Lines 8–31 never raise interrupts, and status bits 31:8 always read zero.
- R11: With its debounce bit set, a line's new input value must hold for 16 consecutive clocks before detection sees it. Shorter pulses are ignored.
- R12: `irq_o` is high exactly when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Access select |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| pready | output | 1 | Access complete, tied high |
| pin_i | input | 32 | Asynchronous pin inputs |
| pout_o | output | 32 | Output latch |
| poe_o | output | 32 | Output enable per line, 1 = output |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bus assertions assume that a write is a single cycle with `psel` and `pwrite` high and a word-aligned address. The bench tasks always drive one such cycle between falling edges and then drop `psel`. The status assertions assume `prdata` is a pure decode of `paddr`, with no read side effects. The bench's pins change only on falling clock edges and then hold for several cycles, so the synchronizer never has to resolve a change that is narrower than a clock. The debounce test deliberately uses pulses of 8 and 25 cycles, which sit on either side of the 16-clock window.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned GPIO_W    = 32;
    localparam int unsigned IRQ_LINES = 8;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DEB_HOLD  = 16;

    // field positions inside the interrupt-control word
    localparam int unsigned RISE_LSB = 0;
    localparam int unsigned FALL_LSB = IRQ_LINES;
    localparam int unsigned DEB_LSB  = 2 * IRQ_LINES;
    localparam int unsigned LVL_LSB  = 3 * IRQ_LINES;

    localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR_SET = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PINS    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_OUT_SET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_OUT_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CTL_SET = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CTL_CLR = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_PCLR    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h24;

    typedef struct packed {
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] dout;
        logic [GPIO_W-1:0] ctrl;
    } bank_regs_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int unsigned N    = 8,
    parameter int unsigned HOLD = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] det_o
);
    localparam int unsigned CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [N-1:0]         filt;
        logic [N-1:0][CW-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (!en_i[i]) begin
                // filter disabled: track the pin so enabling it later is glitch free
                st_d.filt[i] = raw_i[i];
                st_d.cnt[i]  = '0;
            end else if (raw_i[i] == st_q.filt[i]) begin
                st_d.cnt[i] = '0;
            end else if (st_q.cnt[i] == CW'(HOLD - 1)) begin
                st_d.filt[i] = raw_i[i];
                st_d.cnt[i]  = '0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_sel
        assign det_o[g] = en_i[g] ? st_q.filt[g] : raw_i[g];
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] det_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] fall_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] hit;
    } irq_t;

    irq_t         st_d, st_q;
    logic [N-1:0] up, down, live;

    always_comb begin
        up   = det_i & ~st_q.prev;
        down = ~det_i & st_q.prev;
        live = lvl_i & ((rise_i & det_i) | (fall_i & ~det_i));

        st_d      = st_q;
        st_d.prev = det_i;
        // a new edge in the same cycle as a clear wins
        st_d.hit  = (st_q.hit & ~clr_i)
                  | (~lvl_i & rise_i & up)
                  | (~lvl_i & fall_i & down);

        status_o = (st_q.hit | live) & (rise_i | fall_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [GPIO_W-1:0] pwdata,
    output logic [GPIO_W-1:0] prdata,
    output logic              pready,
    input  logic [GPIO_W-1:0] pin_i,
    output logic [GPIO_W-1:0] pout_o,
    output logic [GPIO_W-1:0] poe_o,
    output logic              irq_o
);
    bank_regs_t           regs_d, regs_q;
    logic [GPIO_W-1:0]    pins_sync;
    logic [IRQ_LINES-1:0] det, status, pend_clr;
    logic                 wr_en;

    gpio_sync #(.W(GPIO_W)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pins_sync)
    );

    gpio_debounce #(.N(IRQ_LINES), .HOLD(DEB_HOLD)) i_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (pins_sync[IRQ_LINES-1:0]),
        .en_i  (regs_q.ctrl[DEB_LSB +: IRQ_LINES]),
        .det_o (det)
    );

    gpio_irq_unit #(.N(IRQ_LINES)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_i    (det),
        .rise_i   (regs_q.ctrl[RISE_LSB +: IRQ_LINES]),
        .fall_i   (regs_q.ctrl[FALL_LSB +: IRQ_LINES]),
        .lvl_i    (regs_q.ctrl[LVL_LSB +: IRQ_LINES]),
        .clr_i    (pend_clr),
        .status_o (status)
    );

    assign wr_en    = psel & pwrite;
    assign pend_clr = (wr_en && paddr == OFS_PCLR) ? pwdata[IRQ_LINES-1:0] : '0;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (paddr)
                OFS_DIR_SET: regs_d.dir  = regs_q.dir  |  pwdata;
                OFS_DIR_CLR: regs_d.dir  = regs_q.dir  & ~pwdata;
                OFS_OUT_SET: regs_d.dout = regs_q.dout |  pwdata;
                OFS_OUT_CLR: regs_d.dout = regs_q.dout & ~pwdata;
                OFS_CTL_SET: regs_d.ctrl = regs_q.ctrl |  pwdata;
                OFS_CTL_CLR: regs_d.ctrl = regs_q.ctrl & ~pwdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (paddr)
            OFS_DIR:     prdata = regs_q.dir;
            OFS_PINS:    prdata = pins_sync;
            OFS_OUT_SET: prdata = regs_q.dout;
            OFS_CTL_SET: prdata = regs_q.ctrl;
            OFS_STAT:    prdata = {{(GPIO_W-IRQ_LINES){1'b0}}, status};
            default:     prdata = '0;
        endcase
    end

    assign pready = 1'b1;
    assign pout_o = regs_q.dout;
    assign poe_o  = regs_q.dir;
    assign irq_o  = |status;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [GPIO_W-1:0] pwdata,
    input logic [GPIO_W-1:0] prdata,
    input logic              pready,
    input logic [GPIO_W-1:0] pout_o,
    input logic [GPIO_W-1:0] poe_o,
    input logic              irq_o
);
    // R2
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) pready);

    // R2
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && pwrite && paddr == OFS_DIR_SET) |=> ((poe_o & $past(pwdata)) == $past(pwdata)));

    // R2
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && pwrite && paddr == OFS_DIR_CLR) |=> ((poe_o & $past(pwdata)) == '0));

    // R3
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && pwrite && paddr == OFS_OUT_SET) |=> ((pout_o & $past(pwdata)) == $past(pwdata)));

    // R3
    out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && pwrite && paddr == OFS_OUT_CLR) |=> ((pout_o & $past(pwdata)) == '0));

    // R10
    stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == OFS_STAT) |-> (prdata[GPIO_W-1:IRQ_LINES] == '0));

    // R12
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && paddr == OFS_STAT) |-> (irq_o == (prdata != '0)));
endmodule

bind gpio_irq_bank gpio_irq_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .psel   (psel),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pwdata (pwdata),
    .prdata (prdata),
    .pready (pready),
    .pout_o (pout_o),
    .poe_o  (poe_o),
    .irq_o  (irq_o)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        psel, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata, prdata, pins, pout_o, poe_o;
    logic        pready, irq_o;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pready(pready), .pin_i(pins),
        .pout_o(pout_o), .poe_o(poe_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, exp;
        psel = 0; pwrite = 0; paddr = 0; pwdata = 0; pins = 0; rst_n = 0;
        idle(3);
        rst_n = 1;
        idle(1);

        // R1 reset state
        rd(8'h00, v); check("R1 dir", v, 0);
        rd(8'h10, v); check("R1 out", v, 0);
        rd(8'h18, v); check("R1 ctrl", v, 0);
        rd(8'h24, v); check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
        check("R1 poe", poe_o, 0);

        // R2 direction aliases
        wr(8'h04, 32'hA5A5_0F0F);
        rd(8'h00, v); check("R2 dir set", v, 32'hA5A5_0F0F);
        wr(8'h08, 32'h0000_000F);
        rd(8'h00, v); check("R2 dir clr", v, 32'hA5A5_0F00);
        check("R2 poe", poe_o, 32'hA5A5_0F00);
        check("R2 ready", {31'b0, pready}, 1);
        rd(8'h28, v); check("R2 unmapped", v, 0);

        // R3 output latch
        wr(8'h10, 32'h1234_5678);
        wr(8'h14, 32'h0000_00F0);
        rd(8'h10, v); check("R3 out readback", v, 32'h1234_5608);
        check("R3 pout", pout_o, 32'h1234_5608);

        // R5 control word aliases
        wr(8'h18, 32'hF0F0_F0F0);
        wr(8'h1C, 32'h3000_0030);
        rd(8'h18, v); check("R5 ctrl", v, 32'hC0F0_F0C0);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFF);

        // R4 and R10: upper line is plain GPIO, no interrupt even with rise bits set
        wr(8'h18, 32'h0000_00FF);
        pins = 32'h0010_0000;
        idle(4);
        rd(8'h0C, v); check("R4 pins", v, 32'h0010_0000);
        rd(8'h24, v); check("R10 status", v, 0);
        pins = 0;
        idle(4);
        wr(8'h1C, 32'hFFFF_FFFF);

        // sweep: every interrupt line in every trigger configuration
        for (int ln = 0; ln < 8; ln++) begin
            for (int m = 0; m < 6; m++) begin
                bit r, f, l, sticky;
                string tag;
                r = (m == 0 || m == 2 || m == 3);
                f = (m == 1 || m == 2 || m == 4);
                l = (m >= 3);
                tag = (m == 5) ? "R9" : (l ? "R8" : "R6");
                sticky = 0;
                wr(8'h1C, 32'hFFFF_FFFF);
                pins = 0;
                idle(4);
                wr(8'h20, 32'hFF);
                wr(8'h18, ({31'b0, r} << ln) | ({31'b0, f} << (ln + 8)) | ({31'b0, l} << (ln + 24)));
                idle(3);
                exp = (l & f) ? (32'd1 << ln) : 0;
                rd(8'h24, v); check({tag, " low"}, v, exp);
                pins[ln] = 1'b1;
                idle(4);
                sticky = r & ~l;
                exp = (sticky | (l & r)) ? (32'd1 << ln) : 0;
                rd(8'h24, v); check({tag, " rise"}, v, exp);
                check("R12 irq", {31'b0, irq_o}, {31'b0, exp != 0});
                pins[ln] = 1'b0;
                idle(4);
                sticky = sticky | (f & ~l);
                exp = (sticky | (l & f)) ? (32'd1 << ln) : 0;
                rd(8'h24, v); check({tag, " fall"}, v, exp);
                wr(8'h20, 32'd1 << ln);
                exp = (l & f) ? (32'd1 << ln) : 0;
                rd(8'h24, v); check({tag, " R7 clear"}, v, exp);
            end
        end

        // R7: zero bits in the clear write leave other lines pending
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFF);
        wr(8'h18, 32'h0000_0003);
        pins = 32'h3;
        idle(4);
        rd(8'h24, v); check("R7 both set", v, 32'h3);
        wr(8'h20, 32'h1);
        rd(8'h24, v); check("R7 partial clear", v, 32'h2);
        pins = 0;
        idle(4);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFF);

        // R11 debounce on line 3, rising edge
        wr(8'h18, 32'h0008_0008);
        idle(2);
        pins[3] = 1'b1; idle(8); pins[3] = 1'b0;
        idle(20);
        rd(8'h24, v); check("R11 short pulse", v, 0);
        pins[3] = 1'b1;
        idle(12);
        rd(8'h24, v); check("R11 not yet", v, 0);
        idle(13);
        rd(8'h24, v); check("R11 held", v, 32'h8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule